// File: doc/BRIEF.md
# Software-Managed Translation Table with Probe

This block holds the translation entries of a processor whose page table is walked by software. The table has a fixed number of fully associative entries. Each entry maps a pair of adjacent virtual pages, even and odd, under a per-entry page-size mask. Kernel software loads the PageMask, EntryHi and the two EntryLo register values and then issues one of four operations: write at an explicit index, write at a pseudo-random index, read back an entry, or probe. A probe compares every entry at once against a virtual page number and address-space identifier and returns the lowest matching index, or a miss code.

Each operation is presented for one cycle with `op_valid`. The results are registered and appear with a one-cycle `op_done` strobe. The read outputs and the probe result hold their values until the next operation that updates them. The random-index generator, translation of load and store addresses, and the exception raised on a miss are all outside this block.

Top module: `soft_tlb`

## Requirements
- R1: While reset is asserted and after it is released, every entry holds all-zero register values, `op_done` is low, and all read outputs and `probe_index` are zero.
- R2: The operation code is 0 for an indexed write at `index_sel`, 1 for a write at `random_sel`, 2 for a read of the entry at `index_sel`, and 3 for a probe. A write stores all four register values into the selected entry.
- R3: A write whose selected index is equal to or greater than the entry count (48) changes no entry.
- R4: The global bit of an entry is bit 0 of EntryLo0 AND bit 0 of EntryLo1. A read returns each EntryLo with bit 0 replaced by that global bit and all other bits as written, including the valid bit (bit 1).
- R5: A read returns PageMask exactly as written. It returns EntryHi with bits 12:8 cleared and with every bit cleared that is set in the stored PageMask.
- R6: A probe matches an entry when EntryHi bits 31:13 are equal except at the positions where the entry's size mask (PageMask bits 24:13) has ones, those ones applying to EntryHi bits 24:13. The entry must also be global, or its EntryHi bits 7:0 must equal the probe's EntryHi bits 7:0.
- R7: When several entries match a probe, the lowest index is returned.
- R8: A probe hit sets `probe_index` to the zero-extended entry index. A miss sets it to 0x80000000.
- R9: `op_done` is high for exactly the cycle after each cycle with `op_valid` high, and low otherwise. An operation issued in the cycle right after a write sees the written entry.
- R10: A read whose index is 48 or more leaves all four read outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request, one cycle per operation |
| op_code | input | 2 | 0 indexed write, 1 random write, 2 read, 3 probe |
| index_sel | input | 6 | Low bits of the Index register |
| random_sel | input | 6 | Low bits of the Random register |
| pmask_in | input | 32 | PageMask register value |
| ehi_in | input | 32 | EntryHi register value (also the probe key) |
| elo0_in | input | 32 | EntryLo0 register value |
| elo1_in | input | 32 | EntryLo1 register value |
| op_done | output | 1 | One-cycle completion strobe |
| rd_pmask | output | 32 | PageMask read back |
| rd_ehi | output | 32 | EntryHi read back, reformatted |
| rd_elo0 | output | 32 | EntryLo0 read back, bit 0 is the global bit |
| rd_elo1 | output | 32 | EntryLo1 read back, bit 0 is the global bit |
| probe_index | output | 32 | Matching index, or 0x80000000 on a miss |

## Verification
Two things can collide. A write lands on the same clock edge at which the next operation is accepted. A single probe can also hit more than one entry. The bench drives a write and a probe of the just-written key in consecutive cycles, with `op_valid` held high, and expects a hit at the new index. It loads two entries with the same key, the higher index first, and expects the lower index back. A shadow copy of the table in the bench supplies every expected read and probe value, computed from the masking and matching rules above.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;

    localparam int REG_W    = 32;
    localparam int SIZE_LSB = 13;
    localparam int SIZE_W   = 12;
    localparam int ASID_W   = 8;
    localparam int VPN_W    = REG_W - SIZE_LSB;
    localparam int HOLE_LSB = 8;
    localparam int HOLE_W   = 5;

    typedef enum logic [1:0] {
        OP_WR_IDX = 2'd0,
        OP_WR_RND = 2'd1,
        OP_READ   = 2'd2,
        OP_PROBE  = 2'd3
    } tlb_op_e;

    typedef struct packed {
        logic [REG_W-1:0] pmask;
        logic [REG_W-1:0] ehi;
        logic [REG_W-1:0] elo0;
        logic [REG_W-1:0] elo1;
    } tlb_ent_t;

endpackage

// File: rtl/tlb_table.sv
module tlb_table
    import soft_tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  tlb_ent_t                  wr_data,
    output tlb_ent_t [ENTRIES-1:0]    ents_o
);

    localparam logic [IDX_W:0] ENT_LIM = (IDX_W+1)'(ENTRIES);

    tlb_ent_t [ENTRIES-1:0] ents_d, ents_q;

    always_comb begin
        ents_d = ents_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                ents_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ents_q <= '0;
        end else begin
            ents_q <= ents_d;
        end
    end

    assign ents_o = ents_q;

    // R3: an out-of-range write leaves the whole table untouched
    a_r3_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_idx} >= ENT_LIM)) |=> $stable(ents_q));

    // R2: no write request, no change
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ents_q));

endmodule

// File: rtl/tlb_probe.sv
module tlb_probe
    import soft_tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = 6
) (
    input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [ENTRIES-1:0][SIZE_W-1:0] ent_size,
    input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
    input  logic [ENTRIES-1:0]             ent_glob,
    input  logic [VPN_W-1:0]               key_vpn,
    input  logic [ASID_W-1:0]              key_asid,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx
);

    logic [ENTRIES-1:0] match;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            logic [VPN_W-1:0] care;
            logic             vpn_eq;
            logic             asid_ok;
            assign care    = ~{{(VPN_W-SIZE_W){1'b0}}, ent_size[g]};
            assign vpn_eq  = ((ent_vpn[g] ^ key_vpn) & care) == '0;
            assign asid_ok = ent_glob[g] || (ent_asid[g] == key_asid);
            assign match[g] = vpn_eq && asid_ok;
        end
    endgenerate

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // R7: nothing below the reported index matches
    always_comb begin
        if (hit) begin
            a_r7_lowest_wins: assert ((match & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0);
        end
    end

endmodule

// File: rtl/tlb_readfmt.sv
module tlb_readfmt
    import soft_tlb_pkg::*;
(
    input  tlb_ent_t         ent,
    output logic [REG_W-1:0] pmask_o,
    output logic [REG_W-1:0] ehi_o,
    output logic [REG_W-1:0] elo0_o,
    output logic [REG_W-1:0] elo1_o
);

    localparam logic [REG_W-1:0] HOLE = ((REG_W'(1) << HOLE_W) - REG_W'(1)) << HOLE_LSB;

    logic glob;

    always_comb begin
        glob    = ent.elo0[0] & ent.elo1[0];
        pmask_o = ent.pmask;
        ehi_o   = ent.ehi & ~(ent.pmask | HOLE);
        elo0_o  = {ent.elo0[REG_W-1:1], glob};
        elo1_o  = {ent.elo1[REG_W-1:1], glob};
    end

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import soft_tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [IDX_W-1:0] index_sel,
    input  logic [IDX_W-1:0] random_sel,
    input  logic [31:0]      pmask_in,
    input  logic [31:0]      ehi_in,
    input  logic [31:0]      elo0_in,
    input  logic [31:0]      elo1_in,
    output logic             op_done,
    output logic [31:0]      rd_pmask,
    output logic [31:0]      rd_ehi,
    output logic [31:0]      rd_elo0,
    output logic [31:0]      rd_elo1,
    output logic [31:0]      probe_index
);

    localparam logic [IDX_W:0]   ENT_LIM   = (IDX_W+1)'(ENTRIES);
    localparam logic [REG_W-1:0] MISS_CODE = REG_W'(1) << (REG_W - 1);

    typedef struct packed {
        logic             done;
        logic [REG_W-1:0] pmask;
        logic [REG_W-1:0] ehi;
        logic [REG_W-1:0] elo0;
        logic [REG_W-1:0] elo1;
        logic [REG_W-1:0] prb;
    } out_t;

    tlb_op_e                      op;
    logic                         wr_en;
    logic [IDX_W-1:0]             wr_idx;
    tlb_ent_t                     wr_data;
    tlb_ent_t [ENTRIES-1:0]       ents;
    tlb_ent_t                     rd_ent;
    logic                         rd_ok;
    logic [REG_W-1:0]             f_pmask, f_ehi, f_elo0, f_elo1;
    logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
    logic [ENTRIES-1:0][SIZE_W-1:0] e_size;
    logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
    logic [ENTRIES-1:0]             e_glob;
    logic                         p_hit;
    logic [IDX_W-1:0]             p_idx;
    out_t                         st_d, st_q;

    assign op = tlb_op_e'(op_code);

    always_comb begin
        wr_en  = op_valid && ((op == OP_WR_IDX) || (op == OP_WR_RND));
        wr_idx = (op == OP_WR_RND) ? random_sel : index_sel;
        wr_data.pmask = pmask_in;
        wr_data.ehi   = ehi_in;
        wr_data.elo0  = elo0_in;
        wr_data.elo1  = elo1_in;
    end

    tlb_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .ents_o  (ents)
    );

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_fields
            assign e_vpn[g]  = ents[g].ehi[REG_W-1:SIZE_LSB];
            assign e_size[g] = ents[g].pmask[SIZE_LSB+SIZE_W-1:SIZE_LSB];
            assign e_asid[g] = ents[g].ehi[ASID_W-1:0];
            assign e_glob[g] = ents[g].elo0[0] & ents[g].elo1[0];
        end
    endgenerate

    tlb_probe #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_probe (
        .ent_vpn  (e_vpn),
        .ent_size (e_size),
        .ent_asid (e_asid),
        .ent_glob (e_glob),
        .key_vpn  (ehi_in[REG_W-1:SIZE_LSB]),
        .key_asid (ehi_in[ASID_W-1:0]),
        .hit      (p_hit),
        .hit_idx  (p_idx)
    );

    always_comb begin
        rd_ent = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (index_sel == IDX_W'(i)) begin
                rd_ent = ents[i];
            end
        end
        rd_ok = {1'b0, index_sel} < ENT_LIM;
    end

    tlb_readfmt u_fmt (
        .ent     (rd_ent),
        .pmask_o (f_pmask),
        .ehi_o   (f_ehi),
        .elo0_o  (f_elo0),
        .elo1_o  (f_elo1)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = op_valid;
        if (op_valid && (op == OP_READ) && rd_ok) begin
            st_d.pmask = f_pmask;
            st_d.ehi   = f_ehi;
            st_d.elo0  = f_elo0;
            st_d.elo1  = f_elo1;
        end
        if (op_valid && (op == OP_PROBE)) begin
            st_d.prb = p_hit ? REG_W'(p_idx) : MISS_CODE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_done     = st_q.done;
    assign rd_pmask    = st_q.pmask;
    assign rd_ehi      = st_q.ehi;
    assign rd_elo0     = st_q.elo0;
    assign rd_elo1     = st_q.elo1;
    assign probe_index = st_q.prb;

    // R9: strobe follows each request by one cycle
    a_r9_done_after_op: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> op_done);
    a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !op_done);

    // R8: probe result encoding
    a_r8_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_PROBE) && !p_hit) |=> (probe_index == MISS_CODE));
    a_r8_hit_index: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_PROBE) && p_hit) |=> (probe_index < REG_W'(ENTRIES)));

    // R10: out-of-range read keeps the read outputs
    a_r10_oob_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_READ) && !rd_ok) |=>
            ($stable(rd_pmask) && $stable(rd_ehi) && $stable(rd_elo0) && $stable(rd_elo1)));

    // R5: the cleared field of EntryHi stays clear in every read result
    a_r5_hole_clear: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (rd_ehi[HOLE_LSB+HOLE_W-1:HOLE_LSB] == '0));

endmodule

// File: tb/tb_soft_tlb.sv
module tb_soft_tlb;

    localparam int CLK_PERIOD = 10;
    localparam int N = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [5:0]  index_sel = '0;
    logic [5:0]  random_sel = '0;
    logic [31:0] pmask_in = '0, ehi_in = '0, elo0_in = '0, elo1_in = '0;
    logic        op_done;
    logic [31:0] rd_pmask, rd_ehi, rd_elo0, rd_elo1, probe_index;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] m_pm [N];
    logic [31:0] m_hi [N];
    logic [31:0] m_l0 [N];
    logic [31:0] m_l1 [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    soft_tlb dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .index_sel(index_sel), .random_sel(random_sel),
        .pmask_in(pmask_in), .ehi_in(ehi_in), .elo0_in(elo0_in), .elo1_in(elo1_in),
        .op_done(op_done), .rd_pmask(rd_pmask), .rd_ehi(rd_ehi),
        .rd_elo0(rd_elo0), .rd_elo1(rd_elo1), .probe_index(probe_index)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_probe(input logic [31:0] hi);
        for (int i = 0; i < N; i++) begin
            logic [18:0] care;
            logic        gl;
            care = ~{7'b0, m_pm[i][24:13]};
            gl   = m_l0[i][0] & m_l1[i][0];
            if ((((m_hi[i][31:13] ^ hi[31:13]) & care) == '0) &&
                (gl || (m_hi[i][7:0] == hi[7:0])))
                return 32'(i);
        end
        return 32'h8000_0000;
    endfunction

    task automatic drive(input logic [1:0] code, input int idx, input int rnd,
                         input logic [31:0] pm, input logic [31:0] hi,
                         input logic [31:0] l0, input logic [31:0] l1);
        op_valid   = 1'b1;
        op_code    = code;
        index_sel  = 6'(idx);
        random_sel = 6'(rnd);
        pmask_in   = pm;
        ehi_in     = hi;
        elo0_in    = l0;
        elo1_in    = l1;
        if (code == 2'd0 && idx < N) begin
            m_pm[idx] = pm; m_hi[idx] = hi; m_l0[idx] = l0; m_l1[idx] = l1;
        end
        if (code == 2'd1 && rnd < N) begin
            m_pm[rnd] = pm; m_hi[rnd] = hi; m_l0[rnd] = l0; m_l1[rnd] = l1;
        end
    endtask

    task automatic op(input logic [1:0] code, input int idx, input int rnd,
                      input logic [31:0] pm, input logic [31:0] hi,
                      input logic [31:0] l0, input logic [31:0] l1);
        @(negedge clk);
        drive(code, idx, rnd, pm, hi, l0, l1);
        @(negedge clk);
        op_valid = 1'b0;
        check("R9 done strobe", 32'(op_done), 32'd1);
    endtask

    task automatic wr(input int idx, input logic [31:0] pm, input logic [31:0] hi,
                      input logic [31:0] l0, input logic [31:0] l1);
        op(2'd0, idx, 0, pm, hi, l0, l1);
    endtask

    task automatic read_check(input string tag, input int idx);
        logic [31:0] gl;
        op(2'd2, idx, 0, 32'h0, 32'h0, 32'h0, 32'h0);
        gl = 32'(m_l0[idx][0] & m_l1[idx][0]);
        check({tag, " R5 pagemask"}, rd_pmask, m_pm[idx]);
        check({tag, " R5 entryhi"}, rd_ehi, m_hi[idx] & ~(m_pm[idx] | 32'h0000_1F00));
        check({tag, " R4 entrylo0"}, rd_elo0, {m_l0[idx][31:1], gl[0]});
        check({tag, " R4 entrylo1"}, rd_elo1, {m_l1[idx][31:1], gl[0]});
    endtask

    task automatic probe_check(input string tag, input logic [31:0] hi);
        op(2'd3, 0, 0, 32'h0, hi, 32'h0, 32'h0);
        check({tag, " R8 probe"}, probe_index, m_probe(hi));
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) begin
            m_pm[i] = '0; m_hi[i] = '0; m_l0[i] = '0; m_l1[i] = '0;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 done in reset", 32'(op_done), 32'd0);
        check("R1 probe in reset", probe_index, 32'd0);
        check("R1 ehi in reset", rd_ehi, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", 32'(op_done), 32'd0);
        read_check("R1 cleared entry", 5);
        probe_check("R1 empty table miss", 32'h0000_0005);
        check("R8 miss code", probe_index, 32'h8000_0000);
    endtask

    task automatic t_basic();
        wr(3, 32'h0, 32'h1234_7F05, 32'h0000_0047, 32'h0000_0082);
        read_check("R2 indexed write", 3);
        check("R4 valid bit kept", rd_elo1, 32'h0000_0082);
        check("R5 hole cleared", rd_ehi, 32'h1234_6005);
        probe_check("R6 asid hit", 32'h1234_6005);
        check("R8 hit index", probe_index, 32'd3);
        probe_check("R6 asid mismatch", 32'h1234_6006);
        check("R6 asid mismatch misses", probe_index, 32'h8000_0000);
        @(negedge clk);
        check("R9 done low when idle", 32'(op_done), 32'd0);
    endtask

    task automatic t_global();
        wr(7, 32'h0, 32'h0ABC_2009, 32'h0000_0043, 32'h0000_0041);
        read_check("R4 global", 7);
        check("R4 global bit in elo0", 32'(rd_elo0[0]), 32'd1);
        probe_check("R6 global any asid", 32'h0ABC_2033);
        check("R6 global hit", probe_index, 32'd7);
        wr(8, 32'h0, 32'h0BBC_2009, 32'h0000_0043, 32'h0000_0040);
        read_check("R4 half global", 8);
        probe_check("R6 non-global wrong asid", 32'h0BBC_2033);
        check("R6 non-global miss", probe_index, 32'h8000_0000);
    endtask

    task automatic t_pagesize();
        wr(10, 32'h0001_E000, 32'h4000_0001, 32'h0000_0003, 32'h0000_0002);
        read_check("R5 big page", 10);
        check("R5 mask bits cleared", rd_ehi, 32'h4000_0001);
        probe_check("R6 inside masked range", 32'h4001_E001);
        check("R6 masked hit", probe_index, 32'd10);
        probe_check("R6 outside mask", 32'h4002_0001);
        check("R6 outside mask miss", probe_index, 32'h8000_0000);
    endtask

    task automatic t_priority();
        wr(20, 32'h0, 32'h5555_4011, 32'h0, 32'h0);
        wr(12, 32'h0, 32'h5555_4011, 32'h0, 32'h0);
        probe_check("R7 double match", 32'h5555_4011);
        check("R7 lowest index", probe_index, 32'd12);
    endtask

    task automatic t_random();
        op(2'd1, 2, 25, 32'h0, 32'h6666_0022, 32'h0000_0102, 32'h0000_0101);
        read_check("R2 random write lands", 25);
        read_check("R2 index untouched by random write", 2);
    endtask

    task automatic t_oob();
        read_check("R3 before", 47);
        wr(48, 32'h0, 32'h7777_0033, 32'h3, 32'h3);
        op(2'd1, 0, 63, 32'h0, 32'h7777_0033, 32'h3, 32'h3);
        probe_check("R3 oob writes absent", 32'h7777_0033);
        check("R3 oob write miss", probe_index, 32'h8000_0000);
        read_check("R3 entry 47 unchanged", 47);
        read_check("R10 setup", 3);
        op(2'd2, 50, 0, 32'h0, 32'h0, 32'h0, 32'h0);
        check("R10 pmask held", rd_pmask, 32'h0);
        check("R10 ehi held", rd_ehi, 32'h1234_6005);
        check("R10 elo0 held", rd_elo0, 32'h0000_0046);
        check("R10 elo1 held", rd_elo1, 32'h0000_0082);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        drive(2'd0, 30, 0, 32'h0, 32'h3C3C_8044, 32'h2, 32'h2);
        @(negedge clk);
        check("R9 write done", 32'(op_done), 32'd1);
        drive(2'd3, 0, 0, 32'h0, 32'h3C3C_8044, 32'h0, 32'h0);
        @(negedge clk);
        op_valid = 1'b0;
        check("R9 probe done", 32'(op_done), 32'd1);
        check("R9 probe sees fresh write", probe_index, 32'd30);
        @(negedge clk);
        check("R9 strobe drops", 32'(op_done), 32'd0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_global();
        t_pagesize();
        t_priority();
        t_random();
        t_oob();
        t_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule